// File: doc/BRIEF.md
# Staged Power-Clamp Sequencer

This block owns the 8-bit clamp control words of a group of core power domains, arranged as clusters of cores (two clusters of four by default). A controller asks for one domain to be switched on or off through a valid/ready request port. To switch on, the block steps that domain's clamp word through a five-code ramp. Each code is held for a programmable number of microsecond ticks before the next one is applied. To switch off, it writes the fully closed code once and holds it for one dwell. A single-cycle `done` pulse marks the end of every request, and `done_err` flags a rejected one.

A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a ramp or a closing dwell is in progress, `req_ready` stays low and the request port is back-pressured. A requester may keep `req_valid` high and its fields steady, and the request is taken once the block returns to idle. The microsecond tick is a plain one-cycle strobe from a shared timebase. Ticks only count while a dwell is running.

Top module: `pwr_clamp_seq`

## Requirements
- R1: After reset every clamp word reads 0xFF (closed), `req_ready` is high and `done`/`done_err` are low.
- R2: An accepted switch-on request for a domain whose word is not 0x00 applies the codes 0xFF, 0xFE, 0xF8, 0xF0 and 0x00 to that domain, in that order. The first code appears on the clock edge that accepts the request.
- R3: Each ramp code, and the closing code of a switch-off, is held for exactly `DWELL_TICKS` tick strobes (default 10). The next code, or the end of the request, takes effect on the clock edge that samples the last of those strobes. With no strobe the words do not move.
- R4: A switch-on request for a domain whose word already reads 0x00 changes no word, and `done` rises one cycle after acceptance with `done_err` low.
- R5: An accepted switch-off request writes 0xFF to the domain at acceptance and raises `done` one dwell later.
- R6: The cluster field is 2 bits and the core field is 3 bits. A request with cluster ≥ 2 or core ≥ 4 changes no word and gives `done` together with `done_err` one cycle after acceptance.
- R7: Only one request is in progress at a time. `req_ready` is low from acceptance until the final dwell expires and returns high in the same cycle as `done`. A request presented while `req_ready` is low has no effect.
- R8: Domain index = cluster × 4 + core. Its word occupies `clamp_o[8*index +: 8]`, and at most one domain's word changes per clock.
- R9: `done` is a one-cycle pulse, and `done_err` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle microsecond strobe |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_cluster | input | 2 | Cluster index of the request |
| req_core | input | 3 | Core index within the cluster |
| req_on | input | 1 | 1 = switch on (ramp), 0 = switch off |
| done | output | 1 | Request finished (one-cycle pulse) |
| done_err | output | 1 | Request was rejected (with `done`) |
| clamp_o | output | 64 | Eight clamp words, domain i at bits [8i+7:8i] |

## Verification
The bench counts tick strobes between successive word changes. A dwell that is off by one tick, or that counts clock cycles instead of ticks, therefore shows up directly. It repeats a switch-on of an already open domain, where a design missing the skip would restart the ramp at 0xFF. It issues out-of-range indices, where a design that wraps the index would corrupt a real domain. It also keeps a second request asserted during a ramp, where a design with a leaky `req_ready` would touch a foreign domain or end the first ramp early.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  localparam int CLAMP_W  = 8;
  localparam int RAMP_LEN = 5;
  localparam int STEP_W   = 3;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(RAMP_LEN - 1);
  localparam logic [CLAMP_W-1:0] CODE_CLOSED = 8'hFF;
  localparam logic [CLAMP_W-1:0] CODE_OPEN   = 8'h00;

  typedef enum logic [0:0] {
    SEQ_IDLE  = 1'b0,
    SEQ_DWELL = 1'b1
  } seq_state_t;

  // Clamp code applied at a given ramp step (step 0 is fully closed).
  function automatic logic [CLAMP_W-1:0] ramp_code(input logic [STEP_W-1:0] step);
    case (step)
      3'd0:    ramp_code = 8'hFF;
      3'd1:    ramp_code = 8'hFE;
      3'd2:    ramp_code = 8'hF8;
      3'd3:    ramp_code = 8'hF0;
      default: ramp_code = CODE_OPEN;
    endcase
  endfunction

endpackage

// File: rtl/pcs_req_decode.sv
module pcs_req_decode #(
  parameter int N_CLUSTERS = 2,
  parameter int CORES      = 4,
  parameter int CL_W       = 2,
  parameter int CO_W       = 3,
  parameter int IDX_W      = 3
) (
  input  logic [CL_W-1:0]  cluster,
  input  logic [CO_W-1:0]  core,
  output logic             in_range,
  output logic [IDX_W-1:0] idx
);

  int unsigned flat;

  always_comb begin
    in_range = (int'(cluster) < N_CLUSTERS) && (int'(core) < CORES);
    flat     = int'(cluster) * CORES + int'(core);
    idx      = in_range ? IDX_W'(flat) : '0;
  end

endmodule

// File: rtl/pcs_dwell_timer.sv
module pcs_dwell_timer #(
  parameter int DWELL_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic expire
);

  localparam int CNT_W = $clog2(DWELL_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DWELL_TICKS - 1);

  logic [CNT_W-1:0] cnt;

  assign expire = run && tick && (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (run && tick) begin
      cnt <= expire ? '0 : cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/pcs_clamp_bank.sv
module pcs_clamp_bank
  import pcs_pkg::*;
#(
  parameter int N_DOM = 8,
  parameter int IDX_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [CLAMP_W-1:0]        wr_code,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [CLAMP_W-1:0]        rd_code,
  output logic [N_DOM*CLAMP_W-1:0]  clamp_flat
);

  logic [CLAMP_W-1:0] words [N_DOM];

  for (genvar g = 0; g < N_DOM; g++) begin : g_dom
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words[g] <= CODE_CLOSED;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        words[g] <= wr_code;
      end
    end
    assign clamp_flat[g*CLAMP_W +: CLAMP_W] = words[g];
  end

  always_comb begin
    rd_code = CODE_CLOSED;
    for (int i = 0; i < N_DOM; i++) begin
      if (rd_idx == IDX_W'(i)) rd_code = words[i];
    end
  end

endmodule

// File: rtl/pcs_seq_ctrl.sv
module pcs_seq_ctrl
  import pcs_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_on,
  input  logic               in_range,
  input  logic [IDX_W-1:0]   idx,
  input  logic [CLAMP_W-1:0] cur_code,
  input  logic               expire,
  output logic               req_ready,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [CLAMP_W-1:0] wr_code,
  output logic               tmr_clear,
  output logic               tmr_run,
  output logic               done,
  output logic               done_err
);

  seq_state_t        state;
  logic [STEP_W-1:0] step;
  logic [IDX_W-1:0]  dom;
  logic              accept;
  logic              skip;

  assign req_ready = (state == SEQ_IDLE);
  assign accept    = req_valid && req_ready;
  assign skip      = req_on && (cur_code == CODE_OPEN);
  assign tmr_clear = accept;
  assign tmr_run   = (state == SEQ_DWELL);

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = dom;
    wr_code = CODE_CLOSED;
    if (accept && in_range && !skip) begin
      wr_en   = 1'b1;
      wr_idx  = idx;
      wr_code = req_on ? ramp_code('0) : CODE_CLOSED;
    end else if (tmr_run && expire && (step != LAST_STEP)) begin
      wr_en   = 1'b1;
      wr_code = ramp_code(step + STEP_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      step     <= '0;
      dom      <= '0;
      done     <= 1'b0;
      done_err <= 1'b0;
    end else begin
      done     <= 1'b0;
      done_err <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (accept) begin
            if (!in_range) begin
              done     <= 1'b1;
              done_err <= 1'b1;
            end else if (skip) begin
              done <= 1'b1;
            end else begin
              state <= SEQ_DWELL;
              dom   <= idx;
              step  <= req_on ? '0 : LAST_STEP;
            end
          end
        end
        SEQ_DWELL: begin
          if (expire) begin
            if (step == LAST_STEP) begin
              state <= SEQ_IDLE;
              done  <= 1'b1;
            end else begin
              step <= step + STEP_W'(1);
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pwr_clamp_seq.sv
module pwr_clamp_seq
  import pcs_pkg::*;
#(
  parameter  int N_CLUSTERS        = 2,
  parameter  int CORES_PER_CLUSTER = 4,
  parameter  int DWELL_TICKS       = 10,
  localparam int N_DOM             = N_CLUSTERS * CORES_PER_CLUSTER,
  localparam int IDX_W             = (N_DOM > 1) ? $clog2(N_DOM) : 1,
  localparam int CL_W              = $clog2(N_CLUSTERS) + 1,
  localparam int CO_W              = $clog2(CORES_PER_CLUSTER) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_us,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [CL_W-1:0]          req_cluster,
  input  logic [CO_W-1:0]          req_core,
  input  logic                     req_on,
  output logic                     done,
  output logic                     done_err,
  output logic [N_DOM*CLAMP_W-1:0] clamp_o
);

  logic               in_range;
  logic [IDX_W-1:0]   idx;
  logic [CLAMP_W-1:0] cur_code;
  logic               expire;
  logic               wr_en;
  logic [IDX_W-1:0]   wr_idx;
  logic [CLAMP_W-1:0] wr_code;
  logic               tmr_clear;
  logic               tmr_run;

  pcs_req_decode #(
    .N_CLUSTERS(N_CLUSTERS), .CORES(CORES_PER_CLUSTER),
    .CL_W(CL_W), .CO_W(CO_W), .IDX_W(IDX_W)
  ) u_dec (
    .cluster(req_cluster), .core(req_core), .in_range(in_range), .idx(idx)
  );

  pcs_clamp_bank #(.N_DOM(N_DOM), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_code(wr_code),
    .rd_idx(idx), .rd_code(cur_code), .clamp_flat(clamp_o)
  );

  pcs_dwell_timer #(.DWELL_TICKS(DWELL_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .run(tmr_run),
    .tick(tick_us), .expire(expire)
  );

  pcs_seq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_on(req_on),
    .in_range(in_range), .idx(idx), .cur_code(cur_code), .expire(expire),
    .req_ready(req_ready), .wr_en(wr_en), .wr_idx(wr_idx), .wr_code(wr_code),
    .tmr_clear(tmr_clear), .tmr_run(tmr_run), .done(done), .done_err(done_err)
  );

endmodule

// File: rtl/pcs_chk.sv
module pcs_chk #(
  parameter  int N_CLUSTERS        = 2,
  parameter  int CORES_PER_CLUSTER = 4,
  localparam int N_DOM             = N_CLUSTERS * CORES_PER_CLUSTER,
  localparam int CL_W              = $clog2(N_CLUSTERS) + 1,
  localparam int CO_W              = $clog2(CORES_PER_CLUSTER) + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_us,
  input logic               req_valid,
  input logic               req_ready,
  input logic [CL_W-1:0]    req_cluster,
  input logic [CO_W-1:0]    req_core,
  input logic               req_on,
  input logic               done,
  input logic               done_err,
  input logic [N_DOM*8-1:0] clamp_o
);

  logic             ok_idx;
  logic [7:0]       addr_code;
  logic             take;
  logic [N_DOM*8-1:0] prev;
  logic             primed;
  logic [N_DOM-1:0] chg;

  assign take = req_valid && req_ready;

  always_comb begin
    ok_idx    = (int'(req_cluster) < N_CLUSTERS) && (int'(req_core) < CORES_PER_CLUSTER);
    addr_code = 8'hFF;
    for (int i = 0; i < N_DOM; i++) begin
      if (ok_idx && (i == int'(req_cluster) * CORES_PER_CLUSTER + int'(req_core)))
        addr_code = clamp_o[i*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
      prev   <= '0;
    end else begin
      primed <= 1'b1;
      prev   <= clamp_o;
    end
  end

  for (genvar g = 0; g < N_DOM; g++) begin : g_chg
    assign chg[g] = primed && (prev[g*8 +: 8] != clamp_o[g*8 +: 8]);
  end

  a_r9_err_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done);

  a_r7_ready_back_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> done);

  a_r3_no_tick_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !tick_us) |=> $stable(clamp_o));

  a_r6_reject_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ok_idx) |=> (done && done_err && $stable(clamp_o)));

  a_r4_open_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ok_idx && req_on && (addr_code == 8'h00)) |=> (done && !done_err && $stable(clamp_o)));

  a_r8_one_domain_moves: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chg));

endmodule

bind pwr_clamp_seq pcs_chk #(
  .N_CLUSTERS(N_CLUSTERS), .CORES_PER_CLUSTER(CORES_PER_CLUSTER)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .req_valid(req_valid),
  .req_ready(req_ready), .req_cluster(req_cluster), .req_core(req_core),
  .req_on(req_on), .done(done), .done_err(done_err), .clamp_o(clamp_o)
);

// File: tb/sim_pwr_clamp_seq.sv
module sim_pwr_clamp_seq;

  localparam int NCL = 2;
  localparam int NCO = 4;
  localparam int DW  = 10;
  localparam int ND  = NCL * NCO;
  localparam int W   = ND * 8;
  localparam int TICK_DIV = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick_us = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [1:0]   req_cluster = '0;
  logic [2:0]   req_core = '0;
  logic         req_on = 1'b0;
  logic         done;
  logic         done_err;
  logic [W-1:0] clamp_o;

  always #10 clk = ~clk;

  pwr_clamp_seq #(.N_CLUSTERS(NCL), .CORES_PER_CLUSTER(NCO), .DWELL_TICKS(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .req_valid(req_valid),
    .req_ready(req_ready), .req_cluster(req_cluster), .req_core(req_core),
    .req_on(req_on), .done(done), .done_err(done_err), .clamp_o(clamp_o)
  );

  typedef struct {
    bit           is_done;
    logic [W-1:0] val;
    bit           err;
    int           ticks;
    string        tag;
  } item_t;

  item_t        exp_q[$];
  logic [7:0]   model [ND];
  int           n_cmp = 0;
  int           n_bad = 0;
  int           tick_cnt = 0;
  int           div = 0;
  bit           mon_on = 0;
  bit           prev_done = 0;
  logic [W-1:0] last_seen;

  function automatic logic [W-1:0] pack_model();
    logic [W-1:0] v;
    for (int i = 0; i < ND; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push_clamp(input string tag, input int ticks);
    item_t it;
    it.is_done = 0; it.val = pack_model(); it.err = 0; it.ticks = ticks; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic push_done(input bit err, input int ticks, input string tag);
    item_t it;
    it.is_done = 1; it.val = '0; it.err = err; it.ticks = ticks; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // Monitor and tick source: compares observed events with the scoreboard queue.
  always @(negedge clk) begin
    if (mon_on) begin
      item_t it;
      if (clamp_o !== last_seen) begin
        if (exp_q.size() == 0 || exp_q[0].is_done) begin
          check(0, "R8", "unexpected clamp change", clamp_o, last_seen);
        end else begin
          it = exp_q.pop_front();
          check(clamp_o === it.val, it.tag, "clamp words", clamp_o, it.val);
          check(tick_cnt == it.ticks, "R3", "ticks before change", W'(tick_cnt), W'(it.ticks));
        end
        last_seen = clamp_o;
        tick_cnt  = 0;
      end
      if (prev_done) check(done == 1'b0, "R9", "done longer than one cycle", W'(done), W'(0));
      if (done) begin
        if (exp_q.size() == 0 || !exp_q[0].is_done) begin
          check(0, "R9", "unexpected done", W'(done), W'(0));
        end else begin
          it = exp_q.pop_front();
          check(done_err == it.err, it.tag, "done_err", W'(done_err), W'(it.err));
          check(tick_cnt == it.ticks, "R3", "ticks before done", W'(tick_cnt), W'(it.ticks));
          check(req_ready == 1'b1, "R7", "ready with done", W'(req_ready), W'(1));
        end
        tick_cnt = 0;
      end else if (done_err) begin
        check(0, "R9", "done_err without done", W'(done_err), W'(0));
      end
      prev_done = done;
      if (req_ready) begin
        tick_cnt = 0;
        div      = 0;
        tick_us <= 1'b0;
      end else begin
        div++;
        if (div == TICK_DIV) begin
          div = 0;
          tick_us <= 1'b1;
          tick_cnt++;
        end else begin
          tick_us <= 1'b0;
        end
      end
    end
  end

  // Driver: builds the expected events for one request, then presents it.
  task automatic do_req(input int cl, input int co, input bit on, input string tag,
                        input bit intrude);
    int idx;
    int last_k;
    logic [7:0] codes [5];
    codes[0] = 8'hFF; codes[1] = 8'hFE; codes[2] = 8'hF8; codes[3] = 8'hF0; codes[4] = 8'h00;
    if (cl >= NCL || co >= NCO) begin
      push_done(1, 0, "R6");
    end else begin
      idx = cl * NCO + co;
      if (on && model[idx] == 8'h00) begin
        push_done(0, 0, "R4");
      end else if (on) begin
        last_k = 0;
        for (int k = 0; k < 5; k++) begin
          if (model[idx] != codes[k]) begin
            model[idx] = codes[k];
            push_clamp(tag, (k - last_k) * DW);
            last_k = k;
          end
        end
        push_done(0, (5 - last_k) * DW, tag);
      end else begin
        if (model[idx] != 8'hFF) begin
          model[idx] = 8'hFF;
          push_clamp("R5", 0);
        end
        push_done(0, DW, "R5");
      end
    end
    @(negedge clk);
    req_valid   = 1'b1;
    req_cluster = cl[1:0];
    req_core    = co[2:0];
    req_on      = on;
    @(negedge clk);
    req_valid = 1'b0;
    if (intrude) begin
      @(negedge clk);
      check(req_ready == 1'b0, "R7", "ready during ramp", W'(req_ready), W'(0));
      req_valid   = 1'b1;
      req_cluster = 2'd1;
      req_core    = 3'd0;
      req_on      = 1'b1;
      repeat (20) @(negedge clk);
      req_valid = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    if (intrude)
      check(clamp_o[4*8 +: 8] == 8'hFF, "R7", "ignored request touched domain",
            W'(clamp_o[4*8 +: 8]), W'(8'hFF));
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < ND; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(clamp_o === {ND{8'hFF}}, "R1", "clamp after reset", clamp_o, {ND{8'hFF}});
    check(req_ready === 1'b1, "R1", "ready after reset", W'(req_ready), W'(1));
    check(done === 1'b0 && done_err === 1'b0, "R1", "done after reset", W'({done, done_err}), W'(0));
    last_seen = clamp_o;
    mon_on    = 1;

    do_req(0, 0, 1, "R2", 0);
    do_req(1, 3, 1, "R2", 0);
    do_req(1, 3, 1, "R4", 0);
    do_req(0, 0, 0, "R5", 0);
    do_req(0, 2, 0, "R5", 0);
    do_req(2, 0, 1, "R6", 0);
    do_req(1, 4, 0, "R6", 0);
    do_req(3, 7, 1, "R6", 0);
    do_req(0, 1, 1, "R7", 1);
    do_req(1, 3, 0, "R5", 0);
    do_req(0, 3, 1, "R2", 0);

    check(exp_q.size() == 0, "R2", "events left over", W'(exp_q.size()), W'(0));
    check(clamp_o === pack_model(), "R8", "final words", clamp_o, pack_model());
    finish_run();
  end

endmodule